// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller that groups its pins into banks of up to 32. Software reaches it through a plain single-cycle register bus: a write is taken in the cycle it is presented, and read data appears one clock later. Each bank holds a direction register, an output latch that changes only through separate set and clear ports, a read-only level view of the synchronized pads, rising and falling edge-enable registers, a sticky edge-status register, and an interrupt mask.

Each pad input is brought into the clock domain by a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier. A qualifying edge sets a sticky status bit, which software clears by writing a one to it. Every bank raises its own interrupt when an unmasked status bit is set, and one summary interrupt combines all banks. Banks sit three to a 0x100-byte window at a 4-byte stride, so one register type for neighbouring banks occupies adjacent words. The last bank may carry fewer than 32 pins.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Bank n decodes at byte address ((n / 3) * 0x100) + ((n % 3) * 4) + offset, where the offset is 0x00 level, 0x0C direction, 0x18 set port, 0x24 clear port, 0x30 rising enable, 0x3C falling enable, 0x48 edge status and 0x9C interrupt mask; a write reaches only the addressed bank.
- R2: A direction bit of 1 drives the matching `pin_oe` bit high (output) and 0 makes the pin an input; after reset every direction bit and every output latch bit is 0.
- R3: Writing the set port makes each latch bit whose data bit is 1 go high on `pin_out` from the next cycle; bits written 0 keep their value.
- R4: Writing the clear port makes each latch bit whose data bit is 1 go low from the next cycle; bits written 0 keep their value.
- R5: The level register returns the pad inputs after two synchronizer stages, regardless of the direction setting.
- R6: A status bit becomes set on a synchronized 0-to-1 change with its rising enable set, or a 1-to-0 change with its falling enable set; with both enables set either change sets it, and with neither it stays clear.
- R7: Writing 1 to a status bit clears it, writing 0 leaves it, and writing all ones clears the bank.
- R8: When a qualifying edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R9: A bank's interrupt is high exactly when some status bit is set with its mask bit at 1; the mask resets to all zeros (all masked), and writing all ones unmasks every bit.
- R10: `irq_any` is high when any bank interrupt is high.
- R11: Bits above the pin count of the last bank read as zero in every register and never raise status.
- R12: Reads of the set port, the clear port, misaligned addresses and unmapped addresses return zero, and all read data appears one cycle after the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_in | input | NUM_PINS | Pad inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output enables (direction) |
| bank_irq | output | NUM_BANKS | Per-bank interrupt |
| irq_any | output | 1 | Summary interrupt |

## Verification
The two functions that can land in one cycle are the update of a status bit by a newly detected edge and its clearing by a software write-one-to-clear. The bench sets a status bit, then moves a pad so that the synchronized edge reaches the status register in exactly the cycle that a clear write to that bit is captured, counting the two synchronizer stages and the history flop. It judges the outcome by reading the status back, expecting the bit still set, and then confirms with a lone clear write that the same write does clear the bit when no edge competes.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    K_LEVEL = 4'd0,
    K_DIR   = 4'd1,
    K_SET   = 4'd2,
    K_CLR   = 4'd3,
    K_RISE  = 4'd4,
    K_FALL  = 4'd5,
    K_STS   = 4'd6,
    K_MASK  = 4'd13
  } reg_kind_e;

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;

endmodule

// File: rtl/pbc_addr_dec.sv
module pbc_addr_dec
  import pbc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 4,
  localparam int IDX_W    = ADDR_W - 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  bank_o,
  output reg_kind_e         kind_o
);

  logic [5:0]          word;
  logic [5:0]          kind_raw;
  logic [5:0]          sub;
  logic [ADDR_W-9:0]   grp;
  logic                kind_ok;

  always_comb begin
    word     = addr_i[7:2];
    kind_raw = word / 6'd3;
    sub      = word % 6'd3;
    grp      = addr_i[ADDR_W-1:8];
    bank_o   = IDX_W'(grp) * IDX_W'(3) + IDX_W'(sub);
    kind_ok  = (kind_raw <= 6'd6) || (kind_raw == 6'd13);
    kind_o   = reg_kind_e'(kind_raw[3:0]);
    hit_o    = (addr_i[1:0] == 2'b00) && kind_ok &&
               (bank_o < IDX_W'(NUM_BANKS));
  end

endmodule

// File: rtl/pbc_bank.sv
module pbc_bank
  import pbc_pkg::*;
#(
  parameter int PW       = 32,
  parameter bit HAS_MASK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PW-1:0]     pins_i,
  input  logic              wr_i,
  input  reg_kind_e         kind_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [PW-1:0]     pin_out_o,
  output logic [PW-1:0]     pin_oe_o,
  output logic              irq_o
);

  localparam logic [WORD_W-1:0] IMPL =
    (PW >= WORD_W) ? {WORD_W{1'b1}} : ((WORD_W'(1) << PW) - WORD_W'(1));

  logic [PW-1:0]     lvl_s;
  logic [WORD_W-1:0] lvl;
  logic [WORD_W-1:0] prev_q;
  logic [WORD_W-1:0] dir_q, dir_n;
  logic [WORD_W-1:0] out_q, out_n;
  logic [WORD_W-1:0] rise_en_q, rise_en_n;
  logic [WORD_W-1:0] fall_en_q, fall_en_n;
  logic [WORD_W-1:0] sts_q, sts_n;
  logic [WORD_W-1:0] w1c;
  logic [WORD_W-1:0] rise_hit, fall_hit;
  logic [WORD_W-1:0] msk_eff;
  logic              sts_wr;

  pbc_sync #(.W(PW)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl_s)
  );

  assign lvl = WORD_W'(lvl_s);

  // edge qualification against the previous synchronized sample
  assign rise_hit = lvl & ~prev_q & rise_en_q;
  assign fall_hit = ~lvl & prev_q & fall_en_q;
  assign sts_wr   = wr_i && (kind_i == K_STS);

  // next state
  always_comb begin
    dir_n     = dir_q;
    out_n     = out_q;
    rise_en_n = rise_en_q;
    fall_en_n = fall_en_q;
    w1c       = '0;
    if (wr_i) begin
      case (kind_i)
        K_DIR:   dir_n     = wdata_i & IMPL;
        K_SET:   out_n     = out_q | (wdata_i & IMPL);
        K_CLR:   out_n     = out_q & ~wdata_i;
        K_RISE:  rise_en_n = wdata_i & IMPL;
        K_FALL:  fall_en_n = wdata_i & IMPL;
        K_STS:   w1c       = wdata_i;
        default: ;
      endcase
    end
    // a fresh edge wins over a simultaneous clear
    sts_n = ((sts_q & ~w1c) | rise_hit | fall_hit) & IMPL;
  end

  // configuration registers, enabled by bus writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '0;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (wr_i) begin
      dir_q     <= dir_n;
      out_q     <= out_n;
      rise_en_q <= rise_en_n;
      fall_en_q <= fall_en_n;
    end
  end

  // history and status, updated every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= lvl;
      sts_q  <= sts_n;
    end
  end

  generate
    if (HAS_MASK) begin : g_mask
      logic [WORD_W-1:0] msk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          msk_q <= '0;
        end else if (wr_i && (kind_i == K_MASK)) begin
          msk_q <= wdata_i & IMPL;
        end
      end
      assign msk_eff = msk_q;
    end else begin : g_nomask
      assign msk_eff = IMPL;
    end
  endgenerate

  always_comb begin
    case (kind_i)
      K_LEVEL: rdata_o = lvl;
      K_DIR:   rdata_o = dir_q;
      K_RISE:  rdata_o = rise_en_q;
      K_FALL:  rdata_o = fall_en_q;
      K_STS:   rdata_o = sts_q;
      K_MASK:  rdata_o = msk_eff;
      default: rdata_o = '0;
    endcase
  end

  assign pin_out_o = out_q[PW-1:0];
  assign pin_oe_o  = dir_q[PW-1:0];
  assign irq_o     = |(sts_q & msk_eff);

  // R3: written-one bits of the set port are high next cycle
  a_r3_set_drives_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_SET) |=>
      ((pin_out_o & $past(wdata_i[PW-1:0])) == $past(wdata_i[PW-1:0])));

  // R4: written-one bits of the clear port are low next cycle
  a_r4_clear_drives_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_CLR) |=>
      ((pin_out_o & $past(wdata_i[PW-1:0])) == '0));

  // R6: a status bit can only appear where an edge enable was set
  a_r6_needs_enable : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~($past(rise_en_q) | $past(fall_en_q))) == '0));

  // R7: without a status write, set bits remain set
  a_r7_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R11: nothing lives above the implemented pins
  a_r11_unimpl_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q | dir_q | out_q | rise_en_q | fall_en_q | msk_eff) & ~IMPL) == '0);

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pbc_pkg::*;
#(
  parameter int NUM_PINS  = 100,
  parameter int ADDR_W    = 12,
  parameter bit HAS_MASK  = 1'b1,
  localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W,
  localparam int IDX_W     = ADDR_W - 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic [NUM_BANKS-1:0] bank_irq,
  output logic                 irq_any
);

  logic [1:0]        rst_q;
  logic              rst_ni;
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_bank;
  reg_kind_e         dec_kind;
  logic [NUM_BANKS-1:0] wr_sel;
  logic [WORD_W-1:0] bank_rd [NUM_BANKS];
  logic [WORD_W-1:0] rd_mux;
  logic [WORD_W-1:0] rdata_q, rdata_n;
  logic              rd_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  pbc_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_dec (
    .addr_i(bus_addr),
    .hit_o (dec_hit),
    .bank_o(dec_bank),
    .kind_o(dec_kind)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int PW = (b == NUM_BANKS - 1) ? (NUM_PINS - WORD_W * b) : WORD_W;

      assign wr_sel[b] = bus_sel && bus_wr && dec_hit && (dec_bank == IDX_W'(b));

      pbc_bank #(
        .PW      (PW),
        .HAS_MASK(HAS_MASK)
      ) u_bank (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .pins_i   (pin_in[b*WORD_W +: PW]),
        .wr_i     (wr_sel[b]),
        .kind_i   (dec_kind),
        .wdata_i  (bus_wdata),
        .rdata_o  (bank_rd[b]),
        .pin_out_o(pin_out[b*WORD_W +: PW]),
        .pin_oe_o (pin_oe[b*WORD_W +: PW]),
        .irq_o    (bank_irq[b])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_bank == IDX_W'(b)) rd_mux = bank_rd[b];
    end
    rd_en   = bus_sel && !bus_wr;
    rdata_n = dec_hit ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;
  assign irq_any   = |bank_irq;

  // R1: a write strobe reaches at most one bank
  a_r1_one_bank : assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(wr_sel));

  // R12: an unmapped read returns zero on the next cycle
  a_r12_unmapped_zero : assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_sel && !bus_wr && !dec_hit) |=> (bus_rdata == '0));

  // R10: the summary follows the bank lines
  a_r10_summary : assert property (@(posedge clk) disable iff (!rst_ni)
    ($countones(bank_irq) != 0) == irq_any);

endmodule

// File: tb/pin_bank_ctrl_tb.sv
module pin_bank_ctrl_tb;

  localparam int NP = 100;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_wr;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NB-1:0] bank_irq;
  logic          irq_any;

  int checks   = 0;
  int failures = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        fire_q = 1'b0;

  always #2 clk = ~clk;

  pin_bank_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .bank_irq (bank_irq),
    .irq_any  (irq_any)
  );

  localparam logic [11:0] O_LVL  = 12'h000;
  localparam logic [11:0] O_DIR  = 12'h00C;
  localparam logic [11:0] O_SET  = 12'h018;
  localparam logic [11:0] O_CLR  = 12'h024;
  localparam logic [11:0] O_RISE = 12'h030;
  localparam logic [11:0] O_FALL = 12'h03C;
  localparam logic [11:0] O_STS  = 12'h048;
  localparam logic [11:0] O_MSK  = 12'h09C;

  function automatic logic [11:0] ra(int bank, logic [11:0] off);
    return 12'(((bank / 3) << 8) + ((bank % 3) << 2)) + off;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: issue a read and push what it must return
  task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop and compare one cycle after each read
  always @(posedge clk) fire_q <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (fire_q) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read data actual=%08h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R2: reset state
    check("R2 reset oe", 32'(pin_oe[31:0]), 32'h0);
    check("R2 reset out", 32'(pin_out[31:0]), 32'h0);
    check("R9 reset irq", {31'b0, irq_any}, 32'h0);
    bus_read(ra(0, O_DIR), 32'h0, "R2 reset dir");
    bus_read(ra(0, O_MSK), 32'h0, "R9 reset mask");

    // R2 / R1: direction of bank1
    bus_write(ra(1, O_DIR), 32'h0000_00A5);
    idle(1);
    check("R2 oe bank1", pin_oe[63:32], 32'h0000_00A5);
    bus_read(ra(1, O_DIR), 32'h0000_00A5, "R2 dir readback");
    check("R1 bank0 untouched", pin_oe[31:0], 32'h0);

    // R3 / R4: set and clear ports
    bus_write(ra(0, O_SET), 32'h0000_F0F0);
    bus_write(ra(0, O_SET), 32'h0000_0F00);
    idle(1);
    check("R3 set merge", pin_out[31:0], 32'h0000_FFF0);
    bus_write(ra(0, O_CLR), 32'h0000_00F0);
    idle(1);
    check("R4 clear", pin_out[31:0], 32'h0000_FF00);

    // R1: bank2 at +8, bank3 in second window
    bus_write(ra(2, O_DIR), 32'h1234_5678);
    bus_write(ra(3, O_DIR), 32'h0000_000F);
    idle(1);
    check("R1 bank2 oe", pin_oe[95:64], 32'h1234_5678);
    check("R1 bank3 oe", {28'b0, pin_oe[99:96]}, 32'h0000_000F);
    check("R1 bank1 kept", pin_oe[63:32], 32'h0000_00A5);

    // R5: level regardless of direction
    pin_in[95:64] = 32'hCAFE_BABE;
    idle(4);
    bus_read(ra(2, O_LVL), 32'hCAFE_BABE, "R5 level bank2");

    // R6: enables on bank0
    bus_write(ra(0, O_RISE), 32'h0000_0005);
    bus_write(ra(0, O_FALL), 32'h0000_0006);
    pin_in[2:0] = 3'b111;
    idle(5);
    bus_read(ra(0, O_STS), 32'h0000_0005, "R6 rising");
    bus_write(ra(0, O_STS), 32'hFFFF_FFFF);
    bus_read(ra(0, O_STS), 32'h0, "R7 clear all");
    pin_in[2:0] = 3'b000;
    idle(5);
    bus_read(ra(0, O_STS), 32'h0000_0006, "R6 falling");

    // R7: partial clear
    bus_write(ra(0, O_STS), 32'h0000_0002);
    bus_read(ra(0, O_STS), 32'h0000_0004, "R7 partial");

    // R9 / R10: mask gates the interrupt
    idle(1);
    check("R9 masked irq", {28'b0, bank_irq}, 32'h0);
    bus_write(ra(0, O_MSK), 32'hFFFF_FFFF);
    idle(1);
    check("R9 unmasked irq", {28'b0, bank_irq}, 32'h1);
    check("R10 summary", {31'b0, irq_any}, 32'h1);
    bus_read(ra(0, O_MSK), 32'hFFFF_FFFF, "R9 mask readback");

    // R8: edge and clear in the same cycle (bit2 set, then falls)
    pin_in[2] = 1'b1;
    idle(5);
    bus_write(ra(0, O_STS), 32'h0000_0004);
    bus_read(ra(0, O_STS), 32'h0, "R7 clear bit2");
    pin_in[2] = 1'b0;
    idle(5);
    bus_read(ra(0, O_STS), 32'h0000_0004, "R8 armed");
    pin_in[2] = 1'b1;
    idle(5);
    @(negedge clk);
    pin_in[2] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    bus_write(ra(0, O_STS), 32'h0000_0004);
    bus_read(ra(0, O_STS), 32'h0000_0004, "R8 edge wins");
    bus_write(ra(0, O_STS), 32'h0000_0004);
    bus_read(ra(0, O_STS), 32'h0, "R8 lone clear");
    idle(1);
    check("R10 summary low", {31'b0, irq_any}, 32'h0);

    // R11: partial last bank
    bus_write(ra(3, O_RISE), 32'hFFFF_FFFF);
    bus_read(ra(3, O_RISE), 32'h0000_000F, "R11 rise width");
    bus_write(ra(3, O_DIR), 32'hFFFF_FFFF);
    bus_read(ra(3, O_DIR), 32'h0000_000F, "R11 dir width");
    pin_in[99:96] = 4'hF;
    idle(5);
    bus_read(ra(3, O_STS), 32'h0000_000F, "R11 status width");
    bus_read(ra(3, O_LVL), 32'h0000_000F, "R11 level width");

    // R12: write-only ports and holes read zero
    bus_read(ra(0, O_SET), 32'h0, "R12 set reads zero");
    bus_read(ra(0, O_CLR), 32'h0, "R12 clear reads zero");
    bus_read(12'h060, 32'h0, "R12 unmapped");
    bus_read(12'h00A, 32'h0, "R12 misaligned");
    bus_read(ra(4, O_DIR), 32'h0, "R12 absent bank");

    idle(3);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule